// File: doc/BRIEF.md
# SONET Frame-Synchronous Byte Descrambler

This block removes the frame-synchronous scrambling from an STS-1 byte stream, one byte per clock. An upstream framer supplies each byte with a valid strobe and marks the first byte of every frame with a start-of-frame pulse. The block uses that pulse to keep track of the current row and column in a 9-row by 90-column frame. With that position it knows which bytes to leave untouched and where to restart the sequence.

The descrambling sequence comes from a seven-stage generator with polynomial x^7 + x^6 + 1, so it repeats every 127 bits. It advances eight bit-steps for every payload byte. The generator is reloaded with all ones on the byte that follows the third column of row one. The three overhead bytes at the start of row one pass through unchanged. A configuration bit turns the XOR on or off. Results appear one clock after the input byte.

Top module: `sdscr_top`

## Requirements
- R1: Each descrambled byte is the input XORed with eight consecutive generator bits. The earliest bit goes to bit 7 of the byte. The generator is Fibonacci style: output bit = stage 6, new stage 0 = stage 6 XOR stage 5, shift toward stage 6. Starting from the all-ones load, the first two masks are 0xFE and 0x04.
- R2: The generator is loaded with all ones on row 0, column 3 of every frame. The byte in that position is XORed with 0xFE.
- R3: Bytes at row 0, columns 0 to 2 leave the block unchanged, and the generator does not advance on them.
- R4: The position counters cover 9 rows of 90 columns and step on every valid byte, wrapping from column 89 to column 0 of the next row and from row 8 to row 0. A valid byte with in_sof high sits at row 0, column 0, even in the middle of a frame.
- R5: When cfg_descr_en is low, bytes leave the block unchanged. The generator still advances on payload bytes, so re-enabling within a frame resumes at the correct sequence position.
- R6: out_valid equals in_valid delayed by one clock. out_data holds its last value on clocks that carry no valid input.
- R7: Until the first valid byte with in_sof high arrives after reset, every byte passes unchanged.
- R8: During reset, out_valid and out_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_descr_en | input | 1 | 1 = descramble, 0 = pass through |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | First byte of frame, qualified by in_valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |

## Verification
If the position counter slips by even one byte, the block shows it at the next frame start. The overhead bytes in row one would either come out scrambled or be left unchanged in the wrong place. The mask on the reload byte would also differ from 0xFE. A generator that is stepped once too often or too rarely breaks every following byte within one clock. Because of this, the bench sends all-zero payload stretches, which bring the raw mask straight to the output port. It also places disable windows and early frame starts where any drift between the counters and the generator shows up in the next byte compared.

// File: rtl/sdscr_pkg.sv
package sdscr_pkg;

    localparam int BYTE_W   = 8;
    localparam int GEN_W    = 7;
    localparam int TAP_HI   = 6;
    localparam int TAP_LO   = 5;
    localparam logic [GEN_W-1:0] GEN_SEED = '1;

    typedef struct packed {
        logic [BYTE_W-1:0] mask;
        logic [GEN_W-1:0]  nxt;
    } gen_step_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } out_reg_t;

    // Run the generator BYTE_W bit-steps; earliest bit lands in the MSB.
    function automatic gen_step_t gen_advance(input logic [GEN_W-1:0] s_in);
        gen_step_t         r;
        logic [GEN_W-1:0]  s;
        logic              fb;
        s = s_in;
        r.mask = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            r.mask[i] = s[GEN_W-1];
            fb        = s[TAP_HI] ^ s[TAP_LO];
            s         = {s[GEN_W-2:0], fb};
        end
        r.nxt = s;
        return r;
    endfunction

endpackage

// File: rtl/sdscr_frame_pos.sv
module sdscr_frame_pos #(
    parameter int ROWS    = 9,
    parameter int COLS    = 90,
    parameter int OH_COLS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    output logic synced_o,
    output logic oh_o,
    output logic seed_o
);

    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
    localparam logic [CW-1:0] COL_OH   = CW'(OH_COLS);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          synced;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic          cur_sync;
    logic          sof_hit;

    always_comb begin
        sof_hit  = in_valid && in_sof;
        cur_row  = sof_hit ? '0 : pos_q.row;
        cur_col  = sof_hit ? '0 : pos_q.col;
        cur_sync = sof_hit || pos_q.synced;

        pos_d = pos_q;
        if (in_valid) begin
            pos_d.synced = cur_sync;
            if (cur_col == COL_LAST) begin
                pos_d.col = '0;
                pos_d.row = (cur_row == ROW_LAST) ? '0 : cur_row + 1'b1;
            end else begin
                pos_d.col = cur_col + 1'b1;
                pos_d.row = cur_row;
            end
        end

        synced_o = cur_sync;
        oh_o     = (cur_row == '0) && (cur_col < COL_OH);
        seed_o   = cur_sync && (cur_row == '0) && (cur_col == COL_OH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    // R4
    col_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.col <= COL_LAST);

    // R4
    row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.row <= ROW_LAST);

    // R4
    sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (pos_q.row == '0) && (pos_q.col == CW'(1 % COLS)));

    // R7
    sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.synced |=> pos_q.synced);

endmodule

// File: rtl/sdscr_gen.sv
module sdscr_gen
    import sdscr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              load_i,
    output logic [BYTE_W-1:0] mask_o
);

    logic [GEN_W-1:0] state_d, state_q;
    logic [GEN_W-1:0] base;
    gen_step_t        step;

    always_comb begin
        base    = load_i ? GEN_SEED : state_q;
        step    = gen_advance(base);
        mask_o  = step.mask;
        state_d = (adv_i || load_i) ? step.nxt : state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GEN_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    // R1
    gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R3
    gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(state_q));

endmodule

// File: rtl/sdscr_top.sv
module sdscr_top
    import sdscr_pkg::*;
#(
    parameter int ROWS    = 9,
    parameter int COLS    = 90,
    parameter int OH_COLS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_descr_en,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);

    logic              synced;
    logic              oh_byte;
    logic              seed_byte;
    logic              gen_adv;
    logic              gen_load;
    logic [BYTE_W-1:0] mask;
    out_reg_t          out_d, out_q;

    sdscr_frame_pos #(
        .ROWS    (ROWS),
        .COLS    (COLS),
        .OH_COLS (OH_COLS)
    ) i_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .synced_o (synced),
        .oh_o     (oh_byte),
        .seed_o   (seed_byte)
    );

    sdscr_gen i_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (gen_adv),
        .load_i (gen_load),
        .mask_o (mask)
    );

    always_comb begin
        gen_adv  = in_valid && synced && !oh_byte;
        gen_load = in_valid && seed_byte;

        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.data = (gen_adv && cfg_descr_en) ? (in_data ^ mask) : in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_data  = out_q.data;

    // R6
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R5
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_descr_en) |=> out_data == $past(in_data));

    // R3
    oh_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && synced && oh_byte) |=> out_data == $past(in_data));

    // R7
    unsynced_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !synced) |=> out_data == $past(in_data));

    // R2
    seed_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seed_byte && cfg_descr_en) |=> (out_data ^ $past(in_data)) == 8'hFE);

endmodule

// File: tb/test_sdscr_top.sv
module test_sdscr_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_descr_en = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic [7:0] out_data;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic       valid;
        logic [7:0] data;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    // bench model state
    int         m_row = 0;
    int         m_col = 0;
    bit         m_sync = 0;
    logic [6:0] m_gen = 7'h7F;
    logic [7:0] m_last = 8'h00;

    always #5 clk = ~clk;

    sdscr_top i_sdscr_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_descr_en (cfg_descr_en),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_data     (out_data)
    );

    function automatic logic [7:0] model_mask(inout logic [6:0] g);
        logic [7:0] m;
        for (int b = 7; b >= 0; b--) begin
            m[b] = g[6];
            g = {g[5:0], g[6] ^ g[5]};
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input bit v, input bit s, input bit en, input logic [7:0] d);
        exp_t       e;
        logic [7:0] mask;
        @(negedge clk);
        in_valid     = v;
        in_sof       = s;
        cfg_descr_en = en;
        in_data      = d;
        e.valid = v;
        e.req   = "R6";
        if (v) begin
            if (s) begin
                m_row  = 0;
                m_col  = 0;
                m_sync = 1;
            end
            if (!m_sync) begin
                e.data = d;
                e.req  = "R7";
            end else if (m_row == 0 && m_col < 3) begin
                e.data = d;
                e.req  = "R3";
            end else begin
                if (m_row == 0 && m_col == 3) begin
                    m_gen = 7'h7F;
                    e.req = "R2";
                end else if (m_col == 0) begin
                    e.req = "R4";
                end else begin
                    e.req = "R1";
                end
                mask = model_mask(m_gen);
                if (en) begin
                    e.data = d ^ mask;
                end else begin
                    e.data = d;
                    e.req  = "R5";
                end
            end
            m_last = e.data;
            if (m_col == 89) begin
                m_col = 0;
                m_row = (m_row == 8) ? 0 : m_row + 1;
            end else begin
                m_col++;
            end
        end else begin
            e.data = m_last;
        end
        exp_q.push_back(e);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.req, " valid"}, 32'(out_valid), 32'(e.valid));
            check({e.req, " data"}, 32'(out_data), 32'(e.data));
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [6:0] g;
        // R8: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R8 valid", 32'(out_valid), 32'd0);
        check("R8 data", 32'(out_data), 32'd0);
        // R1: sanity of the expected sequence start
        g = 7'h7F;
        check("R1 mask0", 32'(model_mask(g)), 32'hFE);
        check("R1 mask1", 32'(model_mask(g)), 32'h04);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: bytes before any frame start
        for (int i = 0; i < 6; i++) drive(1, 0, 1, 8'(i * 37 + 5));

        // frame 1: zero payload start exposes raw mask (R1, R2, R3)
        for (int i = 0; i < 810; i++) begin
            drive(1, i == 0, 1, (i < 40) ? 8'h00 : 8'(i * 13));
            if (i % 53 == 7) drive(0, 0, 1, 8'hA5); // R6 idle gaps
        end

        // frame 2: disable window inside the frame (R5)
        for (int i = 0; i < 810; i++) begin
            drive(1, i == 0, !(i >= 100 && i < 200), 8'(i * 7 + 3));
        end

        // frame 3: restarted early by a new frame start (R4)
        for (int i = 0; i < 400; i++) drive(1, i == 0, 1, 8'(i ^ 8'h5A));
        for (int i = 0; i < 820; i++) drive(1, i == 0, 1, (i < 12) ? 8'h00 : 8'(i * 29));

        // R6: trailing idle holds last data
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 8'h3C);
        repeat (4) @(posedge clk);
        #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule